// File: doc/BRIEF.md
# Serial TDM Subscriber Slot: Monitor Handshake and Command Filter

This block attaches to one 32-bit subscriber channel on a framed time-division serial bus. A frame begins when the 8 kHz frame sync rises. The bus carries a whole number of channels per frame, from 4 to 16. Inside its own channel the block transmits a monitor octet together with the receive-acknowledge and transmit-valid flag bits, and it releases the line for every other bit. It also reads the same fields from the incoming line. The bit clock runs at either one or two clock periods per bit. Straps select the rate, the group of four channels and the channel within that group, and they are captured while reset is held.

The transmit side sends one monitor byte and marks it valid with an active-low flag. It repeats the byte in every frame until the far end pulls its acknowledge bit low. The receive side captures each new byte, acknowledges it in the frames that follow, and withdraws the acknowledge when the flag goes inactive or the byte changes. It reports end of message once the flag has stayed inactive for two frames. The four-bit command/indication field is accepted only after the same value appears in two consecutive frames.

Top module: `iom_mon_port`

## Requirements
- R1: A frame starts at the bit-clock rising edge where sync is high and was low at the previous rising edge, and that bit is position 0. Before the first such edge the block never enables its output.
- R2: The rate, group and sub-channel straps are captured only while reset is high. With rate strap 1 each bit lasts one clock period. With rate strap 0 it lasts two periods, is sampled on the second falling edge and is driven on the first rising edge.
- R3: The own channel starts at bit (group*4 + sub)*32. Its offsets are B1 0-7, B2 8-15, monitor 16-23 (MSB first), D 24-25, command 26-29 (MSB first), acknowledge 30 and valid flag 31.
- R4: The output enable is high only at offsets 16-23, 30 and 31 of the own channel. Whenever the enable is low, the output data is 1.
- R5: A load while idle sets busy. From the next frame start the block sends the held byte with the valid flag at 0, and it repeats the byte every frame until acknowledged.
- R6: A transfer is acknowledged at the end of a slot whose sampled acknowledge bit is 0, provided a 1 was sampled in an earlier frame since the load. Busy then clears and the valid flag returns to 1 from the next frame. A stale 0 seen before any 1 does not acknowledge.
- R7: A load while busy is ignored: the byte being sent does not change.
- R8: When the incoming flag is 0 at the end of a slot and no byte is currently acknowledged, the block captures the byte. It presents the byte on rx_data, pulses rx_valid for one clock, and drives its acknowledge bit to 0 from the next frame.
- R9: An acknowledged byte is released, with the acknowledge back at 1 in the next frame, after a frame whose flag is 1 or whose byte differs from the captured one. A differing byte is captured one frame later, not in the frame where the difference is seen.
- R10: eom is 1 after reset and after two or more consecutive frames with the incoming flag at 1. It is 0 after any frame with the flag at 0.
- R11: ci_code resets to 4'hF and takes a new 4-bit value only when the same value arrives in two consecutive frames. Each update pulses ci_change for one clock.
- R12: After reset: dout=1, dout_en=0, tx_busy=0, rx_valid=0 and ci_change=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| dcl | input | 1 | Bus bit clock |
| fsc | input | 1 | 8 kHz frame sync |
| rate_strap | input | 1 | 1 = one clock per bit, 0 = two clocks per bit |
| bank_strap | input | 1 | Selects channels 0-3 (0) or 4-7 (1) |
| sub_strap | input | 2 | Channel within the selected group |
| din | input | 1 | Incoming serial line |
| dout | output | 1 | Outgoing serial data |
| dout_en | output | 1 | Drive enable for dout |
| tx_load | input | 1 | Load strobe for a monitor byte |
| tx_data | input | 8 | Monitor byte to send |
| tx_busy | output | 1 | A transfer is pending or unacknowledged |
| rx_data | output | 8 | Last captured monitor byte |
| rx_valid | output | 1 | One-clock pulse on capture |
| eom | output | 1 | Incoming monitor channel idle (end of message) |
| ci_code | output | 4 | Validated command/indication value |
| ci_change | output | 1 | One-clock pulse when ci_code updates |

## Verification
The bench uses an eight-channel frame of 256 bits. It sweeps all sixteen strap combinations (both rates, both groups, all four sub-channels), with noise in every foreign channel, and compares the whole-frame enable pattern, the byte capture and the command value against positions computed in the bench. A single-rate run on channel 5 then drives an eight-frame script through both handshake directions at once. The script covers a stale low acknowledge, a byte change while acknowledged, a load while busy, the two-frame end-of-message rule and command values that persist for only one frame.

// File: rtl/iom_slot_pkg.sv
package iom_slot_pkg;
    localparam int SLOT_BITS    = 32;
    localparam int MAX_CH       = 16;
    localparam int GROUP_SIZE   = 4;
    localparam int OFF_W        = $clog2(SLOT_BITS);
    localparam int POS_W        = $clog2(MAX_CH * SLOT_BITS) + 1;
    localparam int CHAN_W       = $clog2(2 * GROUP_SIZE);

    localparam logic [OFF_W-1:0] B2_LO  = OFF_W'(8);
    localparam logic [OFF_W-1:0] MON_LO = OFF_W'(16);
    localparam logic [OFF_W-1:0] MON_HI = OFF_W'(23);
    localparam logic [OFF_W-1:0] D_LO   = OFF_W'(24);
    localparam logic [OFF_W-1:0] CI_LO  = OFF_W'(26);
    localparam logic [OFF_W-1:0] ACK_OFF = OFF_W'(30);
    localparam logic [OFF_W-1:0] FLG_OFF = OFF_W'(31);

    typedef enum logic [2:0] {
        FLD_B1, FLD_B2, FLD_MON, FLD_D, FLD_CI, FLD_ACK, FLD_FLG
    } field_e;

    typedef enum logic [1:0] {
        TX_IDLE, TX_PEND, TX_SEND
    } tx_state_e;

    typedef struct packed {
        logic       dbl;
        logic       bank;
        logic [1:0] sub;
    } strap_t;

    function automatic field_e field_of(input logic [OFF_W-1:0] off);
        if (off < B2_LO)        return FLD_B1;
        else if (off < MON_LO)  return FLD_B2;
        else if (off < D_LO)    return FLD_MON;
        else if (off < CI_LO)   return FLD_D;
        else if (off < ACK_OFF) return FLD_CI;
        else if (off == ACK_OFF) return FLD_ACK;
        else                    return FLD_FLG;
    endfunction
endpackage

// File: rtl/iom_bit_timer.sv
module iom_bit_timer
    import iom_slot_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbl,
    input  logic          dcl,
    input  logic          fsc,
    output logic [PW-1:0] pos,
    output logic          drive_stb,
    output logic          samp_stb
);
    localparam logic [PW-1:0] POS_SAT = '1;

    logic          dcl_q, fsc_q, phase, framed;
    logic          rise, fall;
    logic [PW-1:0] pos_inc;

    always_comb begin
        rise    = dcl & ~dcl_q;
        fall    = ~dcl & dcl_q;
        pos_inc = (pos == POS_SAT) ? pos : pos + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcl_q     <= 1'b0;
            fsc_q     <= 1'b0;
            phase     <= 1'b0;
            framed    <= 1'b0;
            pos       <= POS_SAT;
            drive_stb <= 1'b0;
            samp_stb  <= 1'b0;
        end else begin
            dcl_q     <= dcl;
            drive_stb <= 1'b0;
            samp_stb  <= 1'b0;
            if (rise) begin
                fsc_q <= fsc;
                if (fsc && !fsc_q) begin
                    pos       <= '0;
                    phase     <= 1'b0;
                    framed    <= 1'b1;
                    drive_stb <= 1'b1;
                end else if (framed) begin
                    if (dbl) begin
                        phase <= ~phase;
                        if (phase) begin
                            pos       <= pos_inc;
                            drive_stb <= 1'b1;
                        end
                    end else begin
                        pos       <= pos_inc;
                        drive_stb <= 1'b1;
                    end
                end
            end
            if (fall && framed)
                samp_stb <= ~dbl | phase;
        end
    end

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(drive_stb && samp_stb))
        else $error("drive and sample strobes coincide");

    assert_frame_origin_R1: assert property (@(posedge clk) disable iff (rst)
        (drive_stb && pos == '0) |-> $past(fsc))
        else $error("bit 0 driven without sync");
endmodule

// File: rtl/iom_mon_tx.sv
module iom_mon_tx
    import iom_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       frame_stb,
    input  logic       ack_stb,
    input  logic       slot_end,
    input  logic       bit_in,
    output logic [7:0] hold,
    output logic       flag_n,
    output logic       busy
);
    tx_state_e state;
    logic      seen_high, ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            hold      <= 8'hFF;
            seen_high <= 1'b0;
            ack_q     <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: if (load) begin
                    hold      <= load_data;
                    seen_high <= 1'b0;
                    state     <= TX_PEND;
                end
                TX_PEND: if (frame_stb) state <= TX_SEND;
                TX_SEND: begin
                    if (ack_stb) ack_q <= bit_in;
                    if (slot_end) begin
                        if (ack_q)          seen_high <= 1'b1;
                        else if (seen_high) state     <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_n = (state != TX_SEND);
        busy   = (state != TX_IDLE);
    end

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(hold))
        else $error("held byte changed during transfer");
endmodule

// File: rtl/iom_mon_rx.sv
module iom_mon_rx
    import iom_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mon_stb,
    input  logic       slot_end,
    input  logic       bit_in,
    output logic [7:0] data,
    output logic       valid,
    output logic       ack_n,
    output logic       eom
);
    logic [7:0] sr;
    logic       acked;
    logic [1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            data     <= '0;
            valid    <= 1'b0;
            acked    <= 1'b0;
            idle_cnt <= 2'd2;
        end else begin
            valid <= 1'b0;
            if (mon_stb) sr <= {sr[6:0], bit_in};
            if (slot_end) begin
                if (!bit_in) begin
                    idle_cnt <= 2'd0;
                    if (!acked) begin
                        data  <= sr;
                        valid <= 1'b1;
                        acked <= 1'b1;
                    end else if (sr != data) begin
                        acked <= 1'b0;
                    end
                end else begin
                    acked <= 1'b0;
                    if (idle_cnt != 2'd2) idle_cnt <= idle_cnt + 2'd1;
                end
            end
        end
    end

    always_comb begin
        ack_n = ~acked;
        eom   = (idle_cnt == 2'd2);
    end

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid)
        else $error("capture pulse longer than one clock");

    assert_eom_at_slot_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(eom) |-> $past(slot_end))
        else $error("end of message outside slot end");
endmodule

// File: rtl/iom_ci_filter.sv
module iom_ci_filter
    import iom_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ci_stb,
    input  logic       slot_end,
    input  logic       bit_in,
    output logic [3:0] code,
    output logic       change
);
    logic [3:0] sr, last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= 4'hF;
            last   <= 4'hF;
            code   <= 4'hF;
            change <= 1'b0;
        end else begin
            change <= 1'b0;
            if (ci_stb) sr <= {sr[2:0], bit_in};
            if (slot_end) begin
                last <= sr;
                if (sr == last && sr != code) begin
                    code   <= sr;
                    change <= 1'b1;
                end
            end
        end
    end

    assert_ci_update_R11: assert property (@(posedge clk) disable iff (rst)
        change |-> (code != $past(code)))
        else $error("change pulse without new code");
endmodule

// File: rtl/iom_mon_port.sv
module iom_mon_port
    import iom_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dcl,
    input  logic       fsc,
    input  logic       rate_strap,
    input  logic       bank_strap,
    input  logic [1:0] sub_strap,
    input  logic       din,
    output logic       dout,
    output logic       dout_en,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       tx_busy,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       eom,
    output logic [3:0] ci_code,
    output logic       ci_change
);
    localparam int SEL_W = POS_W - OFF_W;

    strap_t             cfg;
    logic [POS_W-1:0]   pos;
    logic               drive_stb, samp_stb;
    logic [OFF_W-1:0]   off;
    logic               in_slot;
    field_e             fld;
    logic [CHAN_W-1:0]  chan;
    logic               mon_stb, ci_stb, ack_stb, slot_end, frame_stb;
    logic [7:0]         tx_hold;
    logic               tx_flag_n, rx_ack_n;

    // R2: straps captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) cfg <= '{dbl: ~rate_strap, bank: bank_strap, sub: sub_strap};
    end

    iom_bit_timer #(.PW(POS_W)) u_timer (
        .clk(clk), .rst(rst), .dbl(cfg.dbl), .dcl(dcl), .fsc(fsc),
        .pos(pos), .drive_stb(drive_stb), .samp_stb(samp_stb)
    );

    // R3: slot placement and field decode
    always_comb begin
        chan      = {cfg.bank, cfg.sub};
        off       = pos[OFF_W-1:0];
        in_slot   = (pos[POS_W-1:OFF_W] == SEL_W'(chan));
        fld       = field_of(off);
        mon_stb   = samp_stb && in_slot && fld == FLD_MON;
        ci_stb    = samp_stb && in_slot && fld == FLD_CI;
        ack_stb   = samp_stb && in_slot && fld == FLD_ACK;
        slot_end  = samp_stb && in_slot && fld == FLD_FLG;
        frame_stb = drive_stb && pos == '0;
    end

    iom_mon_tx u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .load_data(tx_data),
        .frame_stb(frame_stb), .ack_stb(ack_stb), .slot_end(slot_end),
        .bit_in(din), .hold(tx_hold), .flag_n(tx_flag_n), .busy(tx_busy)
    );

    iom_mon_rx u_rx (
        .clk(clk), .rst(rst), .mon_stb(mon_stb), .slot_end(slot_end),
        .bit_in(din), .data(rx_data), .valid(rx_valid), .ack_n(rx_ack_n),
        .eom(eom)
    );

    iom_ci_filter u_ci (
        .clk(clk), .rst(rst), .ci_stb(ci_stb), .slot_end(slot_end),
        .bit_in(din), .code(ci_code), .change(ci_change)
    );

    // R4: output drive, only own monitor, acknowledge and flag bits
    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= 1'b1;
            dout_en <= 1'b0;
        end else if (drive_stb) begin
            dout    <= 1'b1;
            dout_en <= 1'b0;
            if (in_slot) begin
                case (fld)
                    FLD_MON: begin
                        dout    <= tx_hold[3'(MON_HI - off)];
                        dout_en <= 1'b1;
                    end
                    FLD_ACK: begin
                        dout    <= rx_ack_n;
                        dout_en <= 1'b1;
                    end
                    FLD_FLG: begin
                        dout    <= tx_flag_n;
                        dout_en <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_release_level_R4: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> dout)
        else $error("line not released high");

    assert_enable_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_en) |-> $past(drive_stb))
        else $error("enable rose away from a drive point");
endmodule

// File: tb/iom_mon_port_test.sv
module iom_mon_port_test;
    localparam int NCH  = 8;
    localparam int NB   = NCH * 32;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dcl = 1'b0, fsc = 1'b0, din = 1'b1;
    logic rate_strap = 1'b1, bank_strap = 1'b0;
    logic [1:0] sub_strap = 2'd0;
    logic tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic dout, dout_en, tx_busy, rx_valid, eom, ci_change;
    logic [7:0] rx_data;
    logic [3:0] ci_code;

    int n_cmp = 0, n_bad = 0;
    int rxv_cnt = 0, cic_cnt = 0;
    bit finished = 0;
    logic dbl_mode = 1'b0;

    logic in_bits  [NB];
    logic out_bits [NB];
    logic out_en   [NB];

    always #2 clk = ~clk;

    iom_mon_port uut (
        .clk(clk), .rst(rst), .dcl(dcl), .fsc(fsc),
        .rate_strap(rate_strap), .bank_strap(bank_strap), .sub_strap(sub_strap),
        .din(din), .dout(dout), .dout_en(dout_en),
        .tx_load(tx_load), .tx_data(tx_data), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .eom(eom),
        .ci_code(ci_code), .ci_change(ci_change)
    );

    always @(posedge clk) begin
        if (rx_valid)  rxv_cnt <= rxv_cnt + 1;
        if (ci_change) cic_cnt <= cic_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic rate, input logic bank, input logic [1:0] sub);
        @(negedge clk);
        rate_strap = rate; bank_strap = bank; sub_strap = sub;
        dcl = 1'b0; fsc = 1'b0; din = 1'b1; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // flip straps after reset: the captured values must stay in force (R2)
        rate_strap = ~rate; bank_strap = ~bank; sub_strap = ~sub;
        dbl_mode = ~rate;
    endtask

    task automatic fill_noise(input int seed);
        for (int b = 0; b < NB; b++) in_bits[b] = (((b * 5 + seed) % 7) < 3);
    endtask

    task automatic put_slot(input int ch, input logic [7:0] mon, input logic [3:0] ci,
                            input logic ack, input logic flg);
        for (int i = 0; i < 8; i++) in_bits[ch*32 + 16 + i] = mon[7-i];
        for (int i = 0; i < 4; i++) in_bits[ch*32 + 26 + i] = ci[3-i];
        in_bits[ch*32 + 30] = ack;
        in_bits[ch*32 + 31] = flg;
    endtask

    task automatic run_frame();
        int per;
        per = dbl_mode ? 2 : 1;
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < per; p++) begin
                @(negedge clk);
                if (p == 0) begin
                    din = in_bits[b];
                    fsc = (b == 0);
                end
                dcl = 1'b1;
                repeat (HALF - 1) @(negedge clk);
                @(negedge clk);
                dcl = 1'b0;
                repeat (HALF - 1) @(negedge clk);
                if (p == per - 1) begin
                    out_bits[b] = dout;
                    out_en[b]   = dout_en;
                end
            end
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] out_mon(input int ch);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = out_bits[ch*32 + 16 + i];
        return v;
    endfunction

    function automatic int pattern_errors(input int ch);
        int e;
        e = 0;
        for (int b = 0; b < NB; b++) begin
            int o;
            logic exp_en;
            o = b % 32;
            exp_en = (b / 32 == ch) && ((o >= 16 && o <= 23) || o == 30 || o == 31);
            if (out_en[b] != exp_en) e++;
            if (!exp_en && out_bits[b] != 1'b1) e++;
        end
        return e;
    endfunction

    task automatic pulse_load(input logic [7:0] d);
        @(negedge clk);
        tx_data = d; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // configuration sweep: both rates, both groups, all sub-channels
    task automatic sweep();
        for (int c = 0; c < 16; c++) begin
            logic [7:0] mon;
            logic [3:0] ci;
            int ch, rx0;
            ch  = (c & 7);
            mon = {4'(c), ~4'(c)};
            ci  = 4'(c) ^ 4'h6;
            do_reset(~c[3], c[2], c[1:0]);
            fill_noise(c * 3);
            put_slot(ch, mon, ci, 1'b1, 1'b0);
            rx0 = rxv_cnt;
            run_frame();
            chk($sformatf("R2 R3 R4 enable pattern cfg %0d", c), pattern_errors(ch), 0);
            chk($sformatf("R3 R8 captured byte cfg %0d", c), rx_data, mon);
            chk($sformatf("R8 one capture cfg %0d", c), rxv_cnt - rx0, 1);
            chk($sformatf("R8 ack high in capture frame cfg %0d", c), out_bits[ch*32+30], 1);
            chk($sformatf("R5 flag idle cfg %0d", c), out_bits[ch*32+31], 1);
            run_frame();
            chk($sformatf("R8 ack low next frame cfg %0d", c), out_bits[ch*32+30], 0);
            chk($sformatf("R8 no recapture cfg %0d", c), rxv_cnt - rx0, 1);
            chk($sformatf("R11 code after two frames cfg %0d", c), ci_code, ci);
            chk($sformatf("R10 eom low cfg %0d", c), eom, 0);
        end
    endtask

    // handshake script on channel 5 at one clock per bit
    task automatic script();
        logic [7:0] p_mon [8] = '{8'h00, 8'hA5, 8'hA5, 8'h3C, 8'h3C, 8'h00, 8'h00, 8'h00};
        logic [3:0] p_ci  [8] = '{4'h3, 4'h3, 4'h5, 4'h5, 4'h6, 4'h9, 4'h9, 4'h9};
        logic       p_flg [8] = '{1, 0, 0, 0, 0, 1, 1, 1};
        logic       p_ack [8] = '{1, 1, 0, 1, 0, 1, 0, 1};
        logic       e_flg [8] = '{0, 0, 0, 1, 0, 0, 0, 1};
        logic [7:0] e_mon [8] = '{8'h5A, 8'h5A, 8'h5A, 8'h00, 8'hC3, 8'hC3, 8'hC3, 8'h00};
        logic       e_ack [8] = '{1, 1, 0, 0, 1, 0, 1, 1};
        logic       e_bsy [8] = '{1, 1, 0, 0, 1, 1, 0, 0};
        int         e_rxc [8] = '{0, 1, 1, 1, 2, 2, 2, 2};
        logic       e_eom [8] = '{1, 0, 0, 0, 0, 0, 1, 1};
        logic [3:0] e_ci  [8] = '{4'hF, 4'h3, 4'h3, 4'h5, 4'h5, 4'h5, 4'h9, 4'h9};
        int rx0, ci0, en_seen;
        const int ch = 5;

        do_reset(1'b1, 1'b1, 2'd1);
        @(negedge clk);
        chk("R12 reset dout", dout, 1);
        chk("R12 reset dout_en", dout_en, 0);
        chk("R12 reset busy", tx_busy, 0);
        chk("R12 reset rx_valid", rx_valid, 0);
        chk("R12 reset ci_change", ci_change, 0);
        chk("R10 reset eom", eom, 1);
        chk("R11 reset code", ci_code, 4'hF);

        // bit clock running with no sync yet: nothing driven (R1)
        en_seen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            din = k[0];
            dcl = 1'b1;
            repeat (HALF) begin @(negedge clk); if (dout_en) en_seen++; end
            dcl = 1'b0;
            repeat (HALF) begin @(negedge clk); if (dout_en) en_seen++; end
        end
        chk("R1 no drive before first sync", en_seen, 0);

        pulse_load(8'h5A);
        chk("R5 busy after load", tx_busy, 1);
        rx0 = rxv_cnt;
        ci0 = cic_cnt;
        for (int f = 0; f < 8; f++) begin
            if (f == 1) pulse_load(8'hFF);              // R7: load while busy
            if (f == 4) begin
                chk("R6 idle before second load", tx_busy, 0);
                pulse_load(8'hC3);
            end
            fill_noise(f + 11);
            put_slot(ch, p_mon[f], p_ci[f], p_ack[f], p_flg[f]);
            run_frame();
            if (f == 0) chk("R1 R3 R4 frame pattern", pattern_errors(ch), 0);
            chk($sformatf("R5 R6 flag frame %0d", f), out_bits[ch*32+31], e_flg[f]);
            if (!e_flg[f])
                chk($sformatf("R5 R7 monitor byte frame %0d", f), out_mon(ch), e_mon[f]);
            chk($sformatf("R8 R9 ack bit frame %0d", f), out_bits[ch*32+30], e_ack[f]);
            chk($sformatf("R6 busy frame %0d", f), tx_busy, e_bsy[f]);
            chk($sformatf("R8 R9 capture count frame %0d", f), rxv_cnt - rx0, e_rxc[f]);
            chk($sformatf("R10 eom frame %0d", f), eom, e_eom[f]);
            chk($sformatf("R11 code frame %0d", f), ci_code, e_ci[f]);
            if (f == 1) chk("R8 first byte", rx_data, 8'hA5);
            if (f == 4) chk("R9 changed byte", rx_data, 8'h3C);
        end
        chk("R11 change pulses", cic_cnt - ci0, 3);
    endtask

    initial begin
        sweep();
        script();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule